// File: doc/BRIEF.md
# Indirect Register Access Sequencer over a Command Mailbox

This block turns simple register requests into the command traffic of a two-register mailbox. The mailbox has an interface register and a data register. To send a command, the block first writes the payload into the data register. It then writes the opcode, with the run flag set, into the interface register. Next it polls the interface register until the run flag clears, and finally it checks the response code. Every indirect access is wrapped in a transaction of four commands: open a sequence, name the target register, move the data, and close the sequence. Before the close, the block reads the data register back once.

A request is one of three kinds: read, write or read-modify-write. It targets one of two address spaces, a CSR space and an MMIO space. It is offered through a valid/ready handshake. When the final close command completes, the block pulses a response that carries the captured data and an error flag. A command that keeps failing is given up after a bounded number of attempts. The error is then recorded, and the transaction still runs to its close.

Top module: `mbx_seq_top`

## Requirements
- R1: Every write to the interface register (`mb_sel`=0) is directly preceded, in the previous cycle, by a write of the payload to the data register (`mb_sel`=1). The interface word is bit 31 set, bits 30..8 zero and the opcode in bits 7..0.
- R2: A command is complete once a poll of the interface register returns bit 31 clear. A command succeeds only when bits 15..0 then equal 0x0040.
- R3: An attempt is abandoned after MAX_POLLS consecutive polls that return bit 31 set. MAX_POLLS-1 busy polls followed by a clear poll is still a success.
- R4: A non-success code (0x0080 busy, 0x0082 thread unavailable, 0x0090 illegal, or any other value) or a poll timeout reissues the same command. A command is issued at most MAX_TRIES times.
- R5: When MAX_TRIES attempts of a command have failed, the response error flag is set for the request. The remaining commands of the transaction, including the close, are still sent. The flag is cleared when the next request is accepted.
- R6: Opcodes are 0x02 open, 0x03 close, 0x07 data read, 0x08 data write, 0x13 CSR read, 0x14 CSR write, 0x15 MMIO read and 0x16 MMIO write. Sequence IDs are 1 for CSR read, 2 for CSR write, 3 for MMIO read and 4 for MMIO write.
- R7: A transaction issues, in this order: open with the sequence ID as payload; register opcode with the address; data opcode with the write data (zero for reads); one read of the data register; close with the sequence ID. The response follows completion of the close.
- R8: A read-modify-write (`req_kind`=2) runs a complete read transaction and then a complete write transaction. The write data is (old AND `req_and_mask`) OR `req_or_mask`. `rsp_rdata` returns the old value.
- R9: `req_ready` is high only while no request is in progress. `rsp_valid` is a single-cycle pulse. `rsp_rdata` is the data register value captured in the first transaction of the request. `req_kind` 0 is a read and 1 is a write.
- R10: Consecutive polls of the interface register, and the first poll after a command write, are separated by at least POLL_GAP idle cycles.
- R11: After reset, `req_ready` is high and `rsp_valid`, `mb_wr_en` and `mb_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_kind | input | 2 | 0 read, 1 write, 2 read-modify-write |
| req_space | input | 1 | 0 CSR space, 1 MMIO space |
| req_addr | input | 32 | Target register address |
| req_wdata | input | 32 | Write data |
| req_and_mask | input | 32 | AND mask for read-modify-write |
| req_or_mask | input | 32 | OR mask for read-modify-write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Data captured in the first transaction |
| rsp_err | output | 1 | At least one command exhausted its attempts |
| mb_wr_en | output | 1 | Mailbox register write strobe |
| mb_rd_en | output | 1 | Mailbox register read strobe |
| mb_sel | output | 1 | 0 interface register, 1 data register |
| mb_wdata | output | 32 | Mailbox write data |
| mb_rdata | input | 32 | Mailbox read data, valid the cycle after mb_rd_en |

## Verification
The assertions assume that the mailbox returns read data in the cycle after the read strobe. They also assume that the mailbox eventually answers every poll, even if only with a busy flag. The assertions never need the responder to succeed. The bench's responder model is registered, so it always answers one cycle after the strobe. It injects busy polls, failing response codes and permanent failures only through counters that it sets before each request. A request is offered only while `req_ready` is high, and it is withdrawn on the first edge after acceptance.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int          MB_W    = 32;
    localparam int          RUN_BIT = 31;
    localparam logic [15:0] RESP_OK = 16'h0040;

    localparam logic [7:0] OP_OPEN    = 8'h02;
    localparam logic [7:0] OP_CLOSE   = 8'h03;
    localparam logic [7:0] OP_RD_DATA = 8'h07;
    localparam logic [7:0] OP_WR_DATA = 8'h08;
    localparam logic [7:0] OP_REG_BASE = 8'h13;  // CSR read; others follow by +{space,wr}

    localparam logic SEL_IF   = 1'b0;
    localparam logic SEL_DATA = 1'b1;

    localparam logic [1:0] KIND_READ  = 2'd0;
    localparam logic [1:0] KIND_WRITE = 2'd1;
    localparam logic [1:0] KIND_RMW   = 2'd2;

    typedef enum logic [2:0] {
        STEP_OPEN, STEP_REG, STEP_DATA, STEP_FETCH, STEP_CLOSE
    } step_e;

    typedef struct packed {
        logic            fetch;    // read the data register instead of sending a command
        logic [7:0]      op;
        logic [MB_W-1:0] payload;
    } cmd_t;

    function automatic logic [MB_W-1:0] seq_id(input logic space, input logic wr);
        return MB_W'({space, wr}) + MB_W'(1);
    endfunction

    function automatic logic [7:0] reg_opcode(input logic space, input logic wr);
        return OP_REG_BASE + 8'({space, wr});
    endfunction

    function automatic logic [7:0] data_opcode(input logic wr);
        return wr ? OP_WR_DATA : OP_RD_DATA;
    endfunction

    function automatic logic [MB_W-1:0] if_word(input logic [7:0] op);
        return {1'b1, 23'd0, op};
    endfunction

    function automatic step_e next_step(input step_e s);
        case (s)
            STEP_OPEN:  return STEP_REG;
            STEP_REG:   return STEP_DATA;
            STEP_DATA:  return STEP_FETCH;
            default:    return STEP_CLOSE;
        endcase
    endfunction

endpackage

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine
    import mbx_pkg::*;
#(
    parameter int MAX_POLLS = 100,
    parameter int MAX_TRIES = 10,
    parameter int POLL_GAP  = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  cmd_t            cmd,
    output logic            done,
    output logic            fail,
    output logic [MB_W-1:0] fetch_data,
    output logic            mb_wr_en,
    output logic            mb_rd_en,
    output logic            mb_sel,
    output logic [MB_W-1:0] mb_wdata,
    input  logic [MB_W-1:0] mb_rdata
);
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam int TW = $clog2(MAX_TRIES + 1);
    localparam int GW = $clog2(POLL_GAP + 1);

    typedef enum logic [3:0] {
        E_IDLE, E_WDATA, E_WIF, E_GAP, E_POLL, E_PWAIT, E_FRD, E_FWAIT, E_DONE
    } est_e;

    est_e            state;
    cmd_t            cmd_q;
    logic [PW-1:0]   polls;
    logic [TW-1:0]   tries;
    logic [GW-1:0]   gap;
    logic            fail_q;
    logic [MB_W-1:0] fdata_q;

    logic busy_seen, attempt_bad, last_try;
    assign busy_seen   = mb_rdata[RUN_BIT];
    assign attempt_bad = (state == E_PWAIT) &&
                         (busy_seen ? (polls == PW'(MAX_POLLS - 1))
                                    : (mb_rdata[15:0] != RESP_OK));
    assign last_try    = (tries == TW'(MAX_TRIES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= E_IDLE;
            cmd_q   <= '0;
            polls   <= '0;
            tries   <= '0;
            gap     <= '0;
            fail_q  <= 1'b0;
            fdata_q <= '0;
        end else begin
            case (state)
                E_IDLE: if (start) begin
                    cmd_q  <= cmd;
                    tries  <= '0;
                    fail_q <= 1'b0;
                    state  <= cmd.fetch ? E_FRD : E_WDATA;
                end
                E_WDATA: begin
                    polls <= '0;
                    state <= E_WIF;
                end
                E_WIF: begin
                    gap   <= '0;
                    state <= E_GAP;
                end
                E_GAP: begin
                    if (gap == GW'(POLL_GAP - 1)) state <= E_POLL;
                    else                          gap   <= gap + GW'(1);
                end
                E_POLL: state <= E_PWAIT;
                E_PWAIT: begin
                    if (attempt_bad) begin
                        if (last_try) begin
                            fail_q <= 1'b1;
                            state  <= E_DONE;
                        end else begin
                            tries <= tries + TW'(1);
                            state <= E_WDATA;
                        end
                    end else if (busy_seen) begin
                        polls <= polls + PW'(1);
                        gap   <= '0;
                        state <= E_GAP;
                    end else begin
                        state <= E_DONE;
                    end
                end
                E_FRD: state <= E_FWAIT;
                E_FWAIT: begin
                    fdata_q <= mb_rdata;
                    state   <= E_DONE;
                end
                default: state <= E_IDLE;
            endcase
        end
    end

    assign mb_wr_en   = (state == E_WDATA) || (state == E_WIF);
    assign mb_rd_en   = (state == E_POLL)  || (state == E_FRD);
    assign mb_sel     = ((state == E_WDATA) || (state == E_FRD)) ? SEL_DATA : SEL_IF;
    assign mb_wdata   = (state == E_WIF) ? if_word(cmd_q.op) : cmd_q.payload;
    assign done       = (state == E_DONE);
    assign fail       = fail_q;
    assign fetch_data = fdata_q;

    // Observation counters for the checks below
    logic [GW:0] since_if;
    logic [TW:0] issued;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_if <= '0;
            issued   <= '0;
        end else begin
            if ((mb_wr_en || mb_rd_en) && mb_sel == SEL_IF) since_if <= '0;
            else if (since_if < (GW+1)'(POLL_GAP))         since_if <= since_if + (GW+1)'(1);
            if (start && state == E_IDLE)                   issued <= '0;
            else if (mb_wr_en && mb_sel == SEL_IF)          issued <= issued + (TW+1)'(1);
        end
    end

    p_if_after_data_r1: assert property (@(posedge clk) disable iff (rst)
        (mb_wr_en && mb_sel == SEL_IF) |-> $past(mb_wr_en && mb_sel == SEL_DATA));

    p_single_access_r1: assert property (@(posedge clk) disable iff (rst)
        !(mb_wr_en && mb_rd_en));

    p_poll_gap_r10: assert property (@(posedge clk) disable iff (rst)
        (mb_rd_en && mb_sel == SEL_IF) |-> since_if >= (GW+1)'(POLL_GAP));

    p_try_bound_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> issued <= (TW+1)'(MAX_TRIES));

    p_give_up_r5: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> issued == (TW+1)'(MAX_TRIES));

endmodule

// File: rtl/mbx_txn_ctrl.sv
module mbx_txn_ctrl
    import mbx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_kind,
    input  logic            req_space,
    input  logic [MB_W-1:0] req_addr,
    input  logic [MB_W-1:0] req_wdata,
    input  logic [MB_W-1:0] req_and_mask,
    input  logic [MB_W-1:0] req_or_mask,
    output logic            rsp_valid,
    output logic [MB_W-1:0] rsp_rdata,
    output logic            rsp_err,
    output logic            eng_start,
    output cmd_t            eng_cmd,
    input  logic            eng_done,
    input  logic            eng_fail,
    input  logic [MB_W-1:0] eng_rdata
);
    typedef enum logic [1:0] {C_IDLE, C_CMD, C_WAIT, C_RESP} cst_e;

    cst_e            state;
    step_e           step;
    logic            wr_pass;
    logic [1:0]      kind_q;
    logic            space_q;
    logic [MB_W-1:0] addr_q, wdata_q, and_q, or_q, rd_q;
    logic            err_q;

    logic accept, is_rmw, capture;
    assign accept  = (state == C_IDLE) && req_valid;
    assign is_rmw  = (kind_q == KIND_RMW);
    assign capture = !(is_rmw && wr_pass);

    always_comb begin
        eng_cmd = '0;
        case (step)
            STEP_OPEN:  begin eng_cmd.op = OP_OPEN;  eng_cmd.payload = seq_id(space_q, wr_pass); end
            STEP_REG:   begin eng_cmd.op = reg_opcode(space_q, wr_pass); eng_cmd.payload = addr_q; end
            STEP_DATA:  begin eng_cmd.op = data_opcode(wr_pass); eng_cmd.payload = wr_pass ? wdata_q : '0; end
            STEP_FETCH: eng_cmd.fetch = 1'b1;
            default:    begin eng_cmd.op = OP_CLOSE; eng_cmd.payload = seq_id(space_q, wr_pass); end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= C_IDLE;
            step    <= STEP_OPEN;
            wr_pass <= 1'b0;
            kind_q  <= KIND_READ;
            space_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            and_q   <= '0;
            or_q    <= '0;
            rd_q    <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                C_IDLE: if (accept) begin
                    kind_q  <= req_kind;
                    space_q <= req_space;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    and_q   <= req_and_mask;
                    or_q    <= req_or_mask;
                    wr_pass <= (req_kind == KIND_WRITE);
                    err_q   <= 1'b0;
                    step    <= STEP_OPEN;
                    state   <= C_CMD;
                end
                C_CMD: state <= C_WAIT;
                C_WAIT: if (eng_done) begin
                    err_q <= err_q | eng_fail;
                    if (step == STEP_FETCH && capture) rd_q <= eng_rdata;
                    if (step != STEP_CLOSE) begin
                        step  <= next_step(step);
                        state <= C_CMD;
                    end else if (is_rmw && !wr_pass) begin
                        wr_pass <= 1'b1;
                        wdata_q <= (rd_q & and_q) | or_q;
                        step    <= STEP_OPEN;
                        state   <= C_CMD;
                    end else begin
                        state <= C_RESP;
                    end
                end
                default: state <= C_IDLE;
            endcase
        end
    end

    assign req_ready = (state == C_IDLE);
    assign eng_start = (state == C_CMD);
    assign rsp_valid = (state == C_RESP);
    assign rsp_rdata = rd_q;
    assign rsp_err   = err_q;

    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    p_close_before_rsp_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(eng_done && !eng_cmd.fetch && eng_cmd.op == OP_CLOSE));

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (err_q && !accept) |=> err_q);

endmodule

// File: rtl/mbx_seq_top.sv
module mbx_seq_top
    import mbx_pkg::*;
#(
    parameter int MAX_POLLS = 100,
    parameter int MAX_TRIES = 10,
    parameter int POLL_GAP  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_kind,
    input  logic        req_space,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [31:0] req_and_mask,
    input  logic [31:0] req_or_mask,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_err,
    output logic        mb_wr_en,
    output logic        mb_rd_en,
    output logic        mb_sel,
    output logic [31:0] mb_wdata,
    input  logic [31:0] mb_rdata
);
    logic            eng_start, eng_done, eng_fail;
    cmd_t            eng_cmd;
    logic [MB_W-1:0] eng_rdata;

    mbx_txn_ctrl u_ctrl (
        .clk, .rst,
        .req_valid, .req_ready, .req_kind, .req_space, .req_addr,
        .req_wdata, .req_and_mask, .req_or_mask,
        .rsp_valid, .rsp_rdata, .rsp_err,
        .eng_start, .eng_cmd, .eng_done, .eng_fail, .eng_rdata
    );

    mbx_cmd_engine #(
        .MAX_POLLS (MAX_POLLS),
        .MAX_TRIES (MAX_TRIES),
        .POLL_GAP  (POLL_GAP)
    ) u_engine (
        .clk, .rst,
        .start      (eng_start),
        .cmd        (eng_cmd),
        .done       (eng_done),
        .fail       (eng_fail),
        .fetch_data (eng_rdata),
        .mb_wr_en, .mb_rd_en, .mb_sel, .mb_wdata, .mb_rdata
    );

endmodule

// File: tb/mbx_seq_top_tb.sv
`timescale 1ns/1ps
module mbx_seq_top_tb;
    localparam int NP = 4;
    localparam int NT = 3;
    localparam int NG = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic        req_space = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0, req_and_mask = '0, req_or_mask = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        mb_wr_en, mb_rd_en, mb_sel;
    logic [31:0] mb_wdata;
    logic [31:0] mb_rdata = '0;

    always #2.5 clk = ~clk;

    mbx_seq_top #(.MAX_POLLS(NP), .MAX_TRIES(NT), .POLL_GAP(NG)) u_dut (.*);

    int n_checks = 0, n_errs = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- mailbox responder model ----------------
    int          fails_per_cmd = 0;
    logic [15:0] fail_code = 16'h0080;
    int          busy_per_att = 0;
    logic [31:0] data_reg = '0, seq_r = '0, addr_r = '0;
    logic [31:0] mem [0:1][0:15];
    logic [15:0] cur_resp = 16'h0040;
    logic [7:0]  last_op = 8'h00;
    int          cur_fails = 0, busy_left = 0;
    logic [7:0]  log_op [0:63];
    logic [31:0] log_pl [0:63];
    int          log_n = 0;
    int          proto_err = 0, order_err = 0, gap_err = 0;
    int          last_poll = -1000;
    bit          prev_data_wr = 0;

    always @(posedge clk) begin
        if (rst) begin
            data_reg  = '0;
            prev_data_wr = 0;
            for (int s = 0; s < 2; s++) for (int a = 0; a < 16; a++) mem[s][a] = '0;
        end else begin
            if (mb_wr_en && mb_sel) data_reg = mb_wdata;
            if (mb_wr_en && !mb_sel && mb_wdata[31]) begin
                if (!prev_data_wr) order_err++;
                if (mb_wdata[30:8] != 0) order_err++;
                if (log_n < 64) begin log_op[log_n] = mb_wdata[7:0]; log_pl[log_n] = data_reg; end
                log_n++;
                if (mb_wdata[7:0] != last_op) cur_fails = 0;
                last_op   = mb_wdata[7:0];
                busy_left = busy_per_att;
                if (cur_fails < fails_per_cmd) begin
                    cur_resp = fail_code;
                    cur_fails++;
                end else begin
                    cur_resp = 16'h0040;
                    case (mb_wdata[7:0])
                        8'h02: seq_r = data_reg;
                        8'h13, 8'h14, 8'h15, 8'h16: begin
                            addr_r = data_reg;
                            if (mb_wdata[7:0] != 8'h12 + seq_r[7:0]) proto_err++;
                        end
                        8'h07: begin
                            if (seq_r != 1 && seq_r != 3) proto_err++;
                            data_reg = mem[seq_r >= 3][addr_r[3:0]];
                        end
                        8'h08: begin
                            if (seq_r != 2 && seq_r != 4) proto_err++;
                            mem[seq_r >= 3][addr_r[3:0]] = data_reg;
                        end
                        8'h03: if (data_reg != seq_r) proto_err++;
                        default: proto_err++;
                    endcase
                end
            end
            if (mb_rd_en) begin
                if (mb_sel) mb_rdata <= data_reg;
                else begin
                    if (cyc - last_poll < NG + 1) gap_err++;
                    last_poll = cyc;
                    if (busy_left > 0) begin
                        mb_rdata <= 32'h8000_0000;
                        busy_left--;
                    end else mb_rdata <= {16'h0, cur_resp};
                end
            end
            prev_data_wr = mb_wr_en && mb_sel;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [31:0] got_rd;
    logic        got_err;

    task automatic do_req(input logic [1:0] kind, input logic sp, input logic [31:0] addr,
                          input logic [31:0] wd, input logic [31:0] am, input logic [31:0] om);
        int waited;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        log_n = 0;
        req_valid = 1'b1; req_kind = kind; req_space = sp; req_addr = addr;
        req_wdata = wd; req_and_mask = am; req_or_mask = om;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R9 ready low while busy", 32'(req_ready), 32'd0);
        waited = 0;
        while (!rsp_valid && waited < 20000) begin @(negedge clk); waited++; end
        check(rsp_valid == 1'b1, "R9 response arrives", 32'(rsp_valid), 32'd1);
        got_rd  = rsp_rdata;
        got_err = rsp_err;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R9 single-cycle response", 32'(rsp_valid), 32'd0);
    endtask

    logic [31:0] exp_mem [0:1][0:15];

    initial begin : watchdog
        #(150000 * 5);
        n_errs++; n_checks++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] v, old;
        for (int s = 0; s < 2; s++) for (int a = 0; a < 16; a++) exp_mem[s][a] = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R11 reset handshake", {req_ready, rsp_valid}, 32'h2);
        check(mb_wr_en == 1'b0 && mb_rd_en == 1'b0, "R11 reset bus idle", {mb_wr_en, mb_rd_en}, 32'h0);
        rst = 1'b0;

        // R2 R6: clean writes over both spaces
        for (int sp = 0; sp < 2; sp++) begin
            for (int a = 0; a < 4; a++) begin
                v = 32'h1000_0000 * (sp + 1) + 32'h0101_0101 * (a + 3);
                do_req(2'd1, sp[0], 32'(a), v, '0, '0);
                exp_mem[sp][a] = v;
                check(got_err == 1'b0, "R2 clean write no error", 32'(got_err), 0);
                if (sp == 0 && a == 2) begin
                    // R7 R6: CSR write sequence layout
                    check(log_n == 4, "R7 write command count", log_n, 4);
                    check(log_op[0] == 8'h02 && log_pl[0] == 2, "R6 open CSR write", {log_op[0], log_pl[0][7:0]}, 32'h0202);
                    check(log_op[1] == 8'h14 && log_pl[1] == 2, "R7 CSR write register step", {log_op[1], log_pl[1][7:0]}, 32'h1402);
                    check(log_op[2] == 8'h08 && log_pl[2] == v, "R7 data write step", log_pl[2], v);
                    check(log_op[3] == 8'h03 && log_pl[3] == 2, "R7 close CSR write", {log_op[3], log_pl[3][7:0]}, 32'h0302);
                end
            end
        end
        // R2 R6: reads, spaces separate
        for (int sp = 0; sp < 2; sp++) begin
            for (int a = 0; a < 4; a++) begin
                do_req(2'd0, sp[0], 32'(a), 32'hDEAD_BEEF, '0, '0);
                check(got_rd == exp_mem[sp][a], "R2 read back", got_rd, exp_mem[sp][a]);
                if (sp == 1 && a == 1) begin
                    check(log_n == 4 && log_op[0] == 8'h02 && log_pl[0] == 3, "R6 open MMIO read", {log_op[0], log_pl[0][7:0]}, 32'h0203);
                    check(log_op[1] == 8'h15 && log_op[2] == 8'h07 && log_pl[2] == 0, "R7 MMIO read steps", {log_op[1], log_op[2], log_pl[2][15:0]}, 32'h150700);
                    check(log_op[3] == 8'h03 && log_pl[3] == 3, "R7 close MMIO read", {log_op[3], log_pl[3][7:0]}, 32'h0303);
                end
            end
        end

        // R8: read-modify-write patterns
        for (int k = 0; k < 4; k++) begin
            logic [31:0] am, om;
            int sp, a;
            sp = k % 2; a = k;
            am = ~(32'h0000_00FF << (8 * k));
            om = 32'h0000_0011 << (8 * k);
            old = exp_mem[sp][a];
            do_req(2'd2, sp[0], 32'(a), '0, am, om);
            exp_mem[sp][a] = (old & am) | om;
            check(got_rd == old, "R8 returns old value", got_rd, old);
            check(log_n == 8 && log_op[4] == 8'h02 && log_op[6] == 8'h08 && log_pl[6] == exp_mem[sp][a],
                  "R8 write pass data", log_pl[6], exp_mem[sp][a]);
            do_req(2'd0, sp[0], 32'(a), '0, '0, '0);
            check(got_rd == exp_mem[sp][a], "R8 merged value stored", got_rd, exp_mem[sp][a]);
        end

        // R4: failing codes below the attempt limit recover
        for (int c = 0; c < 3; c++) begin
            for (int f = 1; f < NT; f++) begin
                fail_code = (c == 0) ? 16'h0080 : (c == 1) ? 16'h0082 : 16'h0090;
                fails_per_cmd = f;
                v = 32'hA500_0000 + 32'(c * 16 + f);
                do_req(2'd1, 1'b0, 32'd5, v, '0, '0);
                exp_mem[0][5] = v;
                check(got_err == 1'b0, "R4 retry recovers", 32'(got_err), 0);
                check(log_n == 4 * (f + 1), "R4 reissue count", log_n, 4 * (f + 1));
                fails_per_cmd = 0;
                do_req(2'd0, 1'b0, 32'd5, '0, '0, '0);
                check(got_rd == v, "R4 data after retries", got_rd, v);
            end
        end

        // R5: permanent failure flags error yet closes
        fail_code = 16'h0082;
        fails_per_cmd = NT;
        do_req(2'd0, 1'b1, 32'd2, '0, '0, '0);
        check(got_err == 1'b1, "R5 error after exhausted tries", 32'(got_err), 1);
        check(log_n == 4 * NT, "R5 every command tried MAX_TRIES", log_n, 4 * NT);
        check(log_op[4 * NT - 1] == 8'h03, "R5 close still sent", log_op[4 * NT - 1], 8'h03);
        fails_per_cmd = 0;
        do_req(2'd0, 1'b1, 32'd2, '0, '0, '0);
        check(got_err == 1'b0, "R5 error cleared on next request", 32'(got_err), 0);
        check(got_rd == exp_mem[1][2], "R5 later read correct", got_rd, exp_mem[1][2]);

        // R3: poll limit
        busy_per_att = NP - 1;
        do_req(2'd0, 1'b0, 32'd1, '0, '0, '0);
        check(got_err == 1'b0 && log_n == 4, "R3 busy below limit succeeds", {got_err, 8'(log_n)}, 32'h4);
        check(got_rd == exp_mem[0][1], "R3 data under busy polls", got_rd, exp_mem[0][1]);
        busy_per_att = NP;
        do_req(2'd0, 1'b0, 32'd1, '0, '0, '0);
        check(got_err == 1'b1, "R3 poll timeout flags error", 32'(got_err), 1);
        check(log_n == 4 * NT, "R3 timeout triggers reissue", log_n, 4 * NT);
        busy_per_att = 0;

        // R1 R6 R10: bus-level rules seen across the whole run
        check(order_err == 0, "R1 data write precedes command word", order_err, 0);
        check(proto_err == 0, "R6 opcode and sequence consistency", proto_err, 0);
        check(gap_err == 0, "R10 poll spacing", gap_err, 0);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule